// File: doc/BRIEF.md
# Gated Clock Fanout with Synchronous Enables

This block picks one of two clock sources, a fast system clock or a slower scan/test clock, and drives six gated copies of the chosen clock, each with a complementary output. A shared stop control and one stop control per output, all active low, decide which copies run.

The enable controls are registered on the falling edge of whichever clock is selected. An output is therefore started or stopped only while the clock is low. Every pulse that appears on an output is a whole clock pulse, with no runt and no clipped high phase. A disabled output sits low. A synchronous reset puts every enable register in the disabled state.

The clock select is meant to be static, or changed only while all outputs are disabled. Glitch-free switching between the sources is outside the scope of this block.

Top module: `clk_fanout_gate`

## Requirements
- R1: With `src_sel` = 0 the outputs follow `clk_sys`. With `src_sel` = 1 they follow `clk_scan`. Every output is fed by the same selected clock.
- R2: Output n follows the selected clock when the registered `cen_n` and the registered `en_n[n]` are both 0 (asserted).
- R3: An output whose registered individual enable is 1 (deasserted) is held at 0.
- R4: Enables are captured only on a falling edge of the selected clock. A change made while the clock is high does not alter any output before the next falling edge.
- R5: A registered `cen_n` of 1 holds all six outputs at 0, whatever the individual enables are.
- R6: `rst` = 1 at a falling edge of the selected clock sets every enable register to disabled, so all outputs go to 0.
- R7: `gclk_b[n]` is always the exact inverse of `gclk[n]`.
- R8: With the scan clock selected and idle low, every output stays at 0.
- R9: Every high pulse on an output lasts a full high phase of the selected clock, even when its enable toggles at arbitrary times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_sys | input | 1 | Primary system clock |
| clk_scan | input | 1 | Secondary scan/test clock |
| src_sel | input | 1 | Source select: 0 = system, 1 = scan |
| rst | input | 1 | Synchronous active-high reset, sampled on the falling edge of the selected clock |
| cen_n | input | 1 | Common enable, active low |
| en_n | input | 6 | Per-output enables, active low |
| gclk | output | 6 | Gated clock outputs |
| gclk_b | output | 6 | Complements of the gated clocks |

## Verification
The bench changes enables in the middle of a high phase and checks the outputs before the next falling edge. A design that captured enables on the rising edge, or not at all, would change an output early or clip a pulse. It toggles one enable at irregular offsets and measures every resulting high pulse. A level-latch or ungated AND would produce runt pulses shorter than a half period. It samples the scan-selected outputs at two points where the system clock has opposite levels, so a mux stuck on the system clock is caught. It also checks that the common enable overrides the individual enables and that reset or an idle scan clock leaves every output low.

// File: rtl/clkfan_pkg.sv
package clkfan_pkg;
    typedef enum logic {
        SRC_SYS  = 1'b0,
        SRC_SCAN = 1'b1
    } src_e;

    localparam int unsigned FANOUT_DEF = 6;
endpackage

// File: rtl/clkfan_src_mux.sv
module clkfan_src_mux
    import clkfan_pkg::*;
(
    input  logic clk_a,
    input  logic clk_b,
    input  logic sel,
    output logic clk_o
);
    always_comb begin
        if (src_e'(sel) == SRC_SCAN) clk_o = clk_b;
        else                         clk_o = clk_a;
    end
endmodule

// File: rtl/clkfan_en_capture.sv
module clkfan_en_capture #(
    parameter int unsigned NOUT = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cen_n,
    input  logic [NOUT-1:0] en_n,
    output logic [NOUT-1:0] act
);
    typedef struct packed {
        logic            cen_dis;
        logic [NOUT-1:0] en_dis;
    } cap_t;

    cap_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.cen_dis = 1'b1;
            st_d.en_dis  = '1;
        end else begin
            st_d.cen_dis = cen_n;
            st_d.en_dis  = en_n;
        end
    end

    always_ff @(negedge clk) begin
        st_q <= st_d;
    end

    assign act = ~st_q.en_dis & {NOUT{~st_q.cen_dis}};

    AST_COMMON_STOP: assert property (@(negedge clk) disable iff (rst)
        cen_n |=> (act == '0)); // R5

    for (genvar i = 0; i < NOUT; i++) begin : g_chk
        AST_BOTH_ASSERTED_RUNS: assert property (@(negedge clk) disable iff (rst)
            (!cen_n && !en_n[i]) |=> act[i]); // R2
    end
endmodule

// File: rtl/clkfan_gate_cell.sv
module clkfan_gate_cell (
    input  logic clk,
    input  logic act,
    output logic q,
    output logic q_b
);
    logic pass_d;

    always_comb begin
        pass_d = clk & act;
        q      = pass_d;
        q_b    = ~pass_d;
    end
endmodule

// File: rtl/clk_fanout_gate.sv
module clk_fanout_gate #(
    parameter int unsigned NOUT = clkfan_pkg::FANOUT_DEF
) (
    input  logic            clk_sys,
    input  logic            clk_scan,
    input  logic            src_sel,
    input  logic            rst,
    input  logic            cen_n,
    input  logic [NOUT-1:0] en_n,
    output logic [NOUT-1:0] gclk,
    output logic [NOUT-1:0] gclk_b
);
    logic            sel_clk;
    logic [NOUT-1:0] act;

    clkfan_src_mux u_mux (
        .clk_a (clk_sys),
        .clk_b (clk_scan),
        .sel   (src_sel),
        .clk_o (sel_clk)
    );

    clkfan_en_capture #(.NOUT(NOUT)) u_cap (
        .clk   (sel_clk),
        .rst   (rst),
        .cen_n (cen_n),
        .en_n  (en_n),
        .act   (act)
    );

    for (genvar n = 0; n < NOUT; n++) begin : g_out
        clkfan_gate_cell u_cell (
            .clk (sel_clk),
            .act (act[n]),
            .q   (gclk[n]),
            .q_b (gclk_b[n])
        );

        AST_OFF_STAYS_LOW: assert property (@(negedge sel_clk) disable iff (rst)
            !act[n] |-> !gclk[n]); // R3

        AST_FULL_HIGH_PHASE: assert property (@(negedge sel_clk) disable iff (rst)
            act[n] |-> gclk[n]); // R9
    end
endmodule

// File: tb/tb_clk_fanout_gate.sv
`timescale 1ns/1ps
module tb_clk_fanout_gate;
    localparam int NOUT = 6;
    localparam real HALF_SYS = 2.5;

    logic clk_sys = 1'b0, clk_scan = 1'b0, scan_run = 1'b1;
    logic src_sel = 1'b0, rst = 1'b1, cen_n = 1'b0;
    logic [NOUT-1:0] en_n = '0;
    logic [NOUT-1:0] gclk, gclk_b;
    int checks = 0, errors = 0;
    bit meas_on = 1'b0;
    int pulses = 0;
    realtime t_rise = 0.0;

    clk_fanout_gate #(.NOUT(NOUT)) dut (
        .clk_sys(clk_sys), .clk_scan(clk_scan), .src_sel(src_sel), .rst(rst),
        .cen_n(cen_n), .en_n(en_n), .gclk(gclk), .gclk_b(gclk_b)
    );

    initial forever #(HALF_SYS) clk_sys = ~clk_sys;
    initial begin
        #1;
        forever begin
            if (scan_run) begin #20 clk_scan = ~clk_scan; end
            else begin clk_scan = 1'b0; #20; end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [NOUT-1:0] a, input logic [NOUT-1:0] e);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, a, e, $time);
        end
    endtask

    task automatic wait_pos();
        if (src_sel) @(posedge clk_scan); else @(posedge clk_sys);
    endtask
    task automatic wait_neg();
        if (src_sel) @(negedge clk_scan); else @(negedge clk_sys);
    endtask

    // pulse-width monitor on output 0 (R9)
    always @(posedge gclk[0]) t_rise = $realtime;
    always @(negedge gclk[0]) if (meas_on) begin
        pulses++;
        checks++;
        if (($realtime - t_rise) < HALF_SYS - 0.01 || ($realtime - t_rise) > HALF_SYS + 0.01) begin
            errors++;
            $display("FAIL R9 actual width=%0f expected=%0f", $realtime - t_rise, HALF_SYS);
        end
    end

    // {src, cen_n, en_n[5:0], expected gclk[5:0]}
    localparam logic [13:0] VEC [0:10] = '{
        {1'b0, 1'b0, 6'b000000, 6'b111111},
        {1'b0, 1'b0, 6'b101010, 6'b010101},
        {1'b0, 1'b0, 6'b011100, 6'b100011},
        {1'b0, 1'b1, 6'b000000, 6'b000000},
        {1'b0, 1'b0, 6'b111111, 6'b000000},
        {1'b1, 1'b1, 6'b111111, 6'b000000},
        {1'b1, 1'b0, 6'b000000, 6'b111111},
        {1'b1, 1'b0, 6'b110110, 6'b001001},
        {1'b1, 1'b1, 6'b000000, 6'b000000},
        {1'b0, 1'b1, 6'b000000, 6'b000000},
        {1'b0, 1'b0, 6'b111110, 6'b000001}
    };

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [NOUT-1:0] prev;
        // reset state: R6
        repeat (3) @(posedge clk_sys);
        #1;
        chk(gclk == '0, "R6 reset high phase", gclk, '0);
        chk(gclk_b == '1, "R7 reset complement", gclk_b, '1);
        rst = 1'b0;
        wait_neg(); wait_pos(); #1;
        chk(gclk == '1, "R2 all enabled after reset", gclk, '1);
        prev = '1;

        // vector walk: R1 R2 R3 R4 R5 R7
        for (int i = 0; i < 11; i++) begin
            logic [NOUT-1:0] exp_m;
            exp_m = VEC[i][5:0];
            if (VEC[i][13] != src_sel) begin
                src_sel = VEC[i][13];
                repeat (2) wait_pos();
            end
            wait_pos(); #1;
            cen_n = VEC[i][12];
            en_n  = VEC[i][11:6];
            #0.5;
            chk(gclk == prev, "R4 no change during high phase", gclk, prev);
            wait_neg(); wait_pos(); #1;
            chk(gclk == exp_m, src_sel ? "R1 scan high sample" : "R2 R3 R5 high sample", gclk, exp_m);
            chk(gclk_b == ~exp_m, "R7 complement", gclk_b, ~exp_m);
            if (src_sel) begin
                #2.5;
                chk(gclk == exp_m, "R1 scan selected, sys low instant", gclk, exp_m);
            end
            wait_neg(); #1;
            chk(gclk == '0, "R3 low phase", gclk, '0);
            chk(gclk_b == '1, "R7 complement low phase", gclk_b, '1);
            prev = exp_m;
        end

        // R9: toggle en_n[0] at irregular offsets, measure pulses
        wait_pos(); #1;
        cen_n = 1'b0; en_n = '0;
        meas_on = 1'b1;
        for (int k = 0; k < 20; k++) begin
            case (k % 4)
                0: #1.3;
                1: #1.9;
                2: #2.9;
                default: #3.1;
            endcase
            en_n[0] = ~en_n[0];
        end
        en_n[0] = 1'b0;
        repeat (3) wait_pos();
        meas_on = 1'b0;
        chk(pulses > 0, "R9 pulses observed", NOUT'(pulses), '1);

        // mid-run reset: R6
        wait_pos(); #1;
        rst = 1'b1;
        wait_neg(); wait_pos(); #1;
        chk(gclk == '0, "R6 reset mid-run", gclk, '0);
        rst = 1'b0;
        wait_neg(); wait_pos(); #1;
        chk(gclk == '1, "R6 release resumes", gclk, '1);

        // idle scan clock: R8
        cen_n = 1'b1;
        wait_neg(); wait_pos(); #1;
        src_sel = 1'b1;
        scan_run = 1'b0;
        #50;
        cen_n = 1'b0; en_n = '0;
        for (int k = 0; k < 4; k++) begin
            #13;
            chk(gclk == '0, "R8 idle scan low", gclk, '0);
            chk(gclk_b == '1, "R7 idle scan complement", gclk_b, '1);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule